// File: doc/BRIEF.md
# Configurable pixel channel extractor

This block sits between a framebuffer fetch path and a display output stage. Each clock it takes one packed pixel word and splits it into separate red, green and blue channels. It returns each channel as an 8-bit value. The packing is not fixed in logic. A format input gives the pixel size in bytes. Each colour has its own select input that gives where that colour starts in the word and how many bits it uses. The same hardware therefore handles 8-bit, 5-6-5, 24-bit and 32-bit words with any channel order.

Channels narrower than 8 bits are scaled to full range. The field moves to the top of the output byte, and its own most significant bits fill the spare low bits. The red select input also carries a fill colour. All three channels show that colour whenever there is no real pixel to show. This covers the blanking interval, and cycles inside the active region where the fetch path had no data ready. In the second case the block also raises a one-cycle underrun strobe.

There is a single output register stage. Every output changes exactly one clock after the inputs that produced it.

Top module: `pcx_extract`

## Requirements
- R1: While reset is asserted, valid_o, underrun_o, red_o, grn_o and blu_o are all zero.
- R2: Every output appears exactly one clock after the inputs that produced it. valid_o equals the previous cycle's (valid_i AND active_i), and valid_o and underrun_o are never high together.
- R3: pix_fmt_i bits 4:3 hold the pixel size in bytes minus one (0 to 3 for 1 to 4 bytes). Word bits at or above 8 × size are treated as zero during extraction.
- R4: In each select input, bits 4:0 give the channel's bit offset and bits 11:8 give its width. The channel field is word bits [offset + width − 1 : offset]. Bits beyond the word read as zero.
- R5: A field of width w from 1 to 7 is placed at output bits 7:8−w. The low bits below it are filled by repeating the field from its most significant bit downward, so output bit i equals field bit w−1−((7−i) mod w).
- R6: A width of 0 gives a zero channel. A width above 8 is treated as 8.
- R7: When active_i is high and valid_i is low, the next cycle shows red_sel_i bits 23:16 on all three channels, with underrun_o high and valid_o low.
- R8: When active_i is low, the next cycle shows red_sel_i bits 23:16 on all three channels, with valid_o and underrun_o low, whatever valid_i and word_i hold.
- R9: The format and select inputs are used in the same cycle as the pixel word they describe. A new layout applies to the very next pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_fmt_i | input | 8 | Format; bits 4:3 = bytes per pixel minus one |
| red_sel_i | input | 24 | Red offset (4:0), width (11:8), fill colour (23:16) |
| grn_sel_i | input | 12 | Green offset (4:0), width (11:8) |
| blu_sel_i | input | 12 | Blue offset (4:0), width (11:8) |
| active_i | input | 1 | High inside the visible region |
| valid_i | input | 1 | Pixel word present this cycle |
| word_i | input | 32 | Packed pixel word |
| valid_o | output | 1 | Registered pixel valid |
| underrun_o | output | 1 | One-cycle strobe: active region without data |
| red_o | output | 8 | Red channel |
| grn_o | output | 8 | Green channel |
| blu_o | output | 8 | Blue channel |

## Verification
The extractor is driven through several layouts:
- 32-bit with red in the low byte;
- 24-bit with blue in the low byte;
- 5-6-5;
- 8-bit with all three channels on one byte.

Comparing the 32-bit and 24-bit runs separates offset handling from byte order. The 5-6-5 words, with alternating high and low top bits, show whether the low-bit fill repeats the right bits.

Some layouts put a field above the declared pixel size, or use widths of 0 and 12. These expose missing size masking and missing width clamping.

Toggling valid_i and active_i separates the underrun case from the blanking case. A final run picks a random layout every cycle, which checks that a layout change applies to the very next pixel.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int PCX_CH_W = 8;

  typedef struct packed {
    logic [PCX_CH_W-1:0] r;
    logic [PCX_CH_W-1:0] g;
    logic [PCX_CH_W-1:0] b;
  } pcx_rgb_t;
endpackage

// File: rtl/pcx_word_mask.sv
module pcx_word_mask #(
  parameter int PIX_W = 32,
  localparam int BYTES = PIX_W / 8,
  localparam int BPP_W = $clog2(BYTES)
) (
  input  logic [BPP_W-1:0] bpp_m1,
  input  logic [PIX_W-1:0] word,
  output logic [PIX_W-1:0] masked
);
  // keep a byte lane only when it lies inside the declared pixel size
  for (genvar gb = 0; gb < BYTES; gb++) begin : g_lane
    logic keep;
    assign keep = (BPP_W'(gb) <= bpp_m1);
    assign masked[gb*8 +: 8] = keep ? word[gb*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/pcx_chan_unpack.sv
module pcx_chan_unpack #(
  parameter int PIX_W = 32,
  parameter int CH_W  = 8,
  parameter int WID_W = 4,
  localparam int OFS_W = $clog2(PIX_W),
  localparam int REP_W = CH_W * CH_W
) (
  input  logic [PIX_W-1:0] word,
  input  logic [OFS_W-1:0] ofs,
  input  logic [WID_W-1:0] wid,
  output logic [CH_W-1:0]  chan
);
  logic [PIX_W-1:0] shifted;
  logic [WID_W-1:0] wid_eff;
  logic [CH_W-1:0]  fmask;
  logic [CH_W-1:0]  fld;
  logic [REP_W-1:0] rep;
  int unsigned      drop;
  logic             unused_hi;

  assign shifted   = word >> ofs;
  assign unused_hi = ^shifted[PIX_W-1:CH_W];
  assign wid_eff   = (int'(wid) > CH_W) ? WID_W'(CH_W) : wid;

  always_comb begin
    for (int i = 0; i < CH_W; i++) fmask[i] = (i < int'(wid_eff));
    fld = shifted[CH_W-1:0] & fmask;
    // stack the field CH_W times, then keep the top CH_W bits
    rep = '0;
    for (int k = 0; k < CH_W; k++) rep = (rep << wid_eff) | REP_W'(fld);
    drop = 32'(wid_eff) * CH_W - CH_W;
    if (wid_eff == '0) chan = '0;
    else               chan = CH_W'(rep >> drop);
  end
endmodule

// File: rtl/pcx_out_stage.sv
module pcx_out_stage
  import pcx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                valid,
  input  pcx_rgb_t            ext,
  input  logic [PCX_CH_W-1:0] fill,
  output logic                valid_q,
  output logic                under_q,
  output pcx_rgb_t            rgb_q
);
  logic     valid_d, under_d, load_en;
  pcx_rgb_t rgb_d;

  assign load_en = 1'b1;

  always_comb begin
    valid_d = active & valid;
    under_d = active & ~valid;
    rgb_d   = valid_d ? ext : '{r: fill, g: fill, b: fill};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      under_q <= 1'b0;
      rgb_q   <= '0;
    end else if (load_en) begin
      valid_q <= valid_d;
      under_q <= under_d;
      rgb_q   <= rgb_d;
    end
  end
endmodule

// File: rtl/pcx_extract.sv
module pcx_extract
  import pcx_pkg::*;
#(
  parameter int PIX_W    = 32,
  parameter int CH_W     = PCX_CH_W,
  parameter int WID_W    = 4,
  parameter int WID_LSB  = 8,
  parameter int DFLT_LSB = 16,
  parameter int BPP_LSB  = 3,
  parameter int FMT_W    = 8,
  localparam int SEL_W   = WID_LSB + WID_W,
  localparam int RSEL_W  = DFLT_LSB + CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FMT_W-1:0]  pix_fmt_i,
  input  logic [RSEL_W-1:0] red_sel_i,
  input  logic [SEL_W-1:0]  grn_sel_i,
  input  logic [SEL_W-1:0]  blu_sel_i,
  input  logic              active_i,
  input  logic              valid_i,
  input  logic [PIX_W-1:0]  word_i,
  output logic              valid_o,
  output logic              underrun_o,
  output logic [CH_W-1:0]   red_o,
  output logic [CH_W-1:0]   grn_o,
  output logic [CH_W-1:0]   blu_o
);
  localparam int OFS_W = $clog2(PIX_W);
  localparam int BPP_W = $clog2(PIX_W / 8);
  localparam int NCH   = 3;

  logic [BPP_W-1:0]           bpp_m1;
  logic [PIX_W-1:0]           word_m;
  logic [NCH-1:0][SEL_W-1:0]  sel;
  logic [NCH-1:0][CH_W-1:0]   chan;
  pcx_rgb_t                   ext, rgb_q;
  logic                       unused_cfg;

  assign bpp_m1 = pix_fmt_i[BPP_LSB +: BPP_W];
  assign sel[0] = red_sel_i[SEL_W-1:0];
  assign sel[1] = grn_sel_i;
  assign sel[2] = blu_sel_i;

  assign unused_cfg = ^{pix_fmt_i[BPP_LSB-1:0], pix_fmt_i[FMT_W-1:BPP_LSB+BPP_W],
                        red_sel_i[DFLT_LSB-1:SEL_W],
                        sel[0][WID_LSB-1:OFS_W], sel[1][WID_LSB-1:OFS_W],
                        sel[2][WID_LSB-1:OFS_W]};

  pcx_word_mask #(.PIX_W(PIX_W)) u_mask (
    .bpp_m1 (bpp_m1),
    .word   (word_i),
    .masked (word_m)
  );

  for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
    pcx_chan_unpack #(.PIX_W(PIX_W), .CH_W(CH_W), .WID_W(WID_W)) u_unp (
      .word (word_m),
      .ofs  (sel[gc][OFS_W-1:0]),
      .wid  (sel[gc][WID_LSB +: WID_W]),
      .chan (chan[gc])
    );
  end

  assign ext = '{r: chan[0], g: chan[1], b: chan[2]};

  pcx_out_stage u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active_i),
    .valid   (valid_i),
    .ext     (ext),
    .fill    (red_sel_i[DFLT_LSB +: CH_W]),
    .valid_q (valid_o),
    .under_q (underrun_o),
    .rgb_q   (rgb_q)
  );

  assign red_o = rgb_q.r;
  assign grn_o = rgb_q.g;
  assign blu_o = rgb_q.b;
endmodule

// File: rtl/pcx_extract_chk.sv
module pcx_extract_chk #(
  parameter int CH_W     = 8,
  parameter int DFLT_LSB = 16,
  parameter int RSEL_W   = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [RSEL_W-1:0] red_sel_i,
  input logic              active_i,
  input logic              valid_i,
  input logic              valid_o,
  input logic              underrun_o,
  input logic [CH_W-1:0]   red_o,
  input logic [CH_W-1:0]   grn_o,
  input logic [CH_W-1:0]   blu_o
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> valid_o == $past(valid_i && active_i));

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && underrun_o));

  a_r7_underrun_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> underrun_o == $past(active_i && !valid_i));

  a_r7_fill_colour: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && underrun_o) |->
      (red_o == $past(red_sel_i[DFLT_LSB +: CH_W]) &&
       grn_o == $past(red_sel_i[DFLT_LSB +: CH_W]) &&
       blu_o == $past(red_sel_i[DFLT_LSB +: CH_W])));

  a_r8_blank_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!active_i)) |->
      (!valid_o && !underrun_o &&
       grn_o == $past(red_sel_i[DFLT_LSB +: CH_W])));
endmodule

bind pcx_extract pcx_extract_chk #(.CH_W(CH_W), .DFLT_LSB(DFLT_LSB), .RSEL_W(RSEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .red_sel_i  (red_sel_i),
  .active_i   (active_i),
  .valid_i    (valid_i),
  .valid_o    (valid_o),
  .underrun_o (underrun_o),
  .red_o      (red_o),
  .grn_o      (grn_o),
  .blu_o      (blu_o)
);

// File: tb/tb_pcx_extract.sv
module tb_pcx_extract;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  pix_fmt_i;
  logic [23:0] red_sel_i;
  logic [11:0] grn_sel_i, blu_sel_i;
  logic        active_i, valid_i;
  logic [31:0] word_i;
  logic        valid_o, underrun_o;
  logic [7:0]  red_o, grn_o, blu_o;

  always #5 clk = ~clk;

  pcx_extract dut (
    .clk(clk), .rst_n(rst_n), .pix_fmt_i(pix_fmt_i), .red_sel_i(red_sel_i),
    .grn_sel_i(grn_sel_i), .blu_sel_i(blu_sel_i), .active_i(active_i),
    .valid_i(valid_i), .word_i(word_i), .valid_o(valid_o),
    .underrun_o(underrun_o), .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench-side configuration (plain integers)
  int c_bpp, c_ro, c_rw, c_go, c_gw, c_bo, c_bw, c_fill;
  // expected outputs for the next sample
  logic       e_v, e_u;
  logic [7:0] e_r, e_g, e_b;
  string      e_tag;

  function automatic logic [7:0] ref_ch(logic [31:0] w, int bpp, int ofs, int wid);
    longint unsigned x;
    longint unsigned fld;
    int n;
    logic [7:0] res;
    n = (wid > 8) ? 8 : wid;
    if (n == 0) return 8'h00;
    x = 64'(w);
    if (bpp < 4) x = x & ((64'd1 << (8 * bpp)) - 1);
    fld = (x >> ofs) & ((64'd1 << n) - 1);
    for (int i = 0; i < 8; i++) res[i] = fld[n - 1 - ((7 - i) % n)];
    return res;
  endfunction

  task automatic cfg(int bpp, int ro, int rw, int go, int gw, int bo, int bw, int fill);
    c_bpp = bpp; c_ro = ro; c_rw = rw; c_go = go; c_gw = gw;
    c_bo = bo; c_bw = bw; c_fill = fill;
  endtask

  task automatic check_now();
    n_chk++;
    if ({valid_o, underrun_o, red_o, grn_o, blu_o} !== {e_v, e_u, e_r, e_g, e_b}) begin
      n_fail++;
      $display("FAIL %s: got v=%0b u=%0b rgb=%02h %02h %02h exp v=%0b u=%0b rgb=%02h %02h %02h",
               e_tag, valid_o, underrun_o, red_o, grn_o, blu_o, e_v, e_u, e_r, e_g, e_b);
    end
  endtask

  // one cycle: check previous result, drive new inputs, predict
  task automatic step(string tag, logic act, logic vld, logic [31:0] w);
    @(negedge clk);
    check_now();
    pix_fmt_i = 8'((c_bpp - 1) << 3);
    red_sel_i = {8'(c_fill), 4'h0, 4'(c_rw), 3'b000, 5'(c_ro)};
    grn_sel_i = {4'(c_gw), 3'b000, 5'(c_go)};
    blu_sel_i = {4'(c_bw), 3'b000, 5'(c_bo)};
    active_i = act; valid_i = vld; word_i = w;
    e_tag = tag;
    e_v = act & vld;
    e_u = act & ~vld;
    if (e_v) begin
      e_r = ref_ch(w, c_bpp, c_ro, c_rw);
      e_g = ref_ch(w, c_bpp, c_go, c_gw);
      e_b = ref_ch(w, c_bpp, c_bo, c_bw);
    end else begin
      e_r = 8'(c_fill); e_g = 8'(c_fill); e_b = 8'(c_fill);
    end
  endtask

  initial begin
    rst_n = 1'b0; active_i = 0; valid_i = 0; word_i = '0;
    pix_fmt_i = '0; red_sel_i = '0; grn_sel_i = '0; blu_sel_i = '0;
    cfg(4, 0, 8, 8, 8, 16, 8, 8'h3C);
    e_v = 0; e_u = 0; e_r = 0; e_g = 0; e_b = 0; e_tag = "R1 reset";
    repeat (3) @(negedge clk);
    check_now();                       // R1: outputs zero while in reset
    active_i = 1; valid_i = 1; word_i = 32'hFFFF_FFFF;
    @(negedge clk);
    check_now();                       // R1: still zero with busy inputs
    active_i = 0; valid_i = 0;
    rst_n = 1'b1;

    // R3/R4: 32-bit, red in low byte
    cfg(4, 0, 8, 8, 8, 16, 8, 8'h3C);
    step("R4 32bit", 1, 1, 32'hFF33_2211);
    step("R4 32bit", 1, 1, 32'h80C0_E0F0);
    // R3/R4: 24-bit, blue in low byte, top byte ignored
    cfg(3, 16, 8, 8, 8, 0, 8, 8'h3C);
    step("R3 24bit", 1, 1, 32'hAA12_3456);
    // R3: field above pixel size reads zero
    cfg(3, 24, 8, 20, 8, 0, 8, 8'h3C);
    step("R3 size mask", 1, 1, 32'hFFFF_FFFF);
    cfg(2, 8, 8, 12, 8, 0, 8, 8'h3C);
    step("R3 size mask", 1, 1, 32'hFFFF_ABCD);
    // R5: 5-6-5
    cfg(2, 11, 5, 5, 6, 0, 5, 8'h3C);
    step("R5 565", 1, 1, 32'h0000_F800);
    step("R5 565", 1, 1, 32'h0000_07E0);
    step("R5 565", 1, 1, 32'h0000_8410);
    step("R5 565", 1, 1, 32'h0000_5AEB);
    // 8-bit words, all channels share the byte; R5 with 3-bit fields
    cfg(1, 5, 3, 2, 3, 0, 2, 8'h3C);
    step("R5 8bit", 1, 1, 32'h1234_56B7);
    // R6: width 0 and width above 8
    cfg(4, 4, 0, 4, 12, 20, 15, 8'h3C);
    step("R6 width", 1, 1, 32'h9876_5432);
    // R4: offsets near the top of the word
    cfg(4, 28, 8, 30, 4, 31, 1, 8'h3C);
    step("R4 high ofs", 1, 1, 32'hC000_0000);
    // R7: underrun inside active region
    cfg(4, 0, 8, 8, 8, 16, 8, 8'hA5);
    step("R7 underrun", 1, 0, 32'h1234_5678);
    step("R2 recover", 1, 1, 32'h1234_5678);
    step("R7 underrun", 1, 0, 32'h0);
    // R8: blanking, with and without valid
    cfg(4, 0, 8, 8, 8, 16, 8, 8'h5A);
    step("R8 blank", 0, 1, 32'hDEAD_BEEF);
    step("R8 blank", 0, 0, 32'hDEAD_BEEF);
    // R2: valid toggling pattern
    for (int i = 0; i < 12; i++)
      step("R2 latency", 1, 1'(i % 3 != 1), 32'(i * 32'h0101_0303));
    // R9: layout changes every cycle
    for (int i = 0; i < 400; i++) begin
      int sel = int'($urandom_range(0, 3));
      case (sel)
        0: cfg(4, 0, 8, 8, 8, 16, 8, int'($urandom_range(0, 255)));
        1: cfg(3, 16, 8, 8, 8, 0, 8, int'($urandom_range(0, 255)));
        2: cfg(2, 11, 5, 5, 6, 0, 5, int'($urandom_range(0, 255)));
        default: cfg(int'($urandom_range(1, 4)), int'($urandom_range(0, 31)),
                     int'($urandom_range(0, 15)), int'($urandom_range(0, 31)),
                     int'($urandom_range(0, 15)), int'($urandom_range(0, 31)),
                     int'($urandom_range(0, 15)), int'($urandom_range(0, 255)));
      endcase
      step("R9 random", 1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 5) != 0),
           $urandom());
    end
    @(negedge clk);
    check_now();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule